// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Decode Mode

This block holds eight single-bit storage cells. A 3-bit select picks one cell, and a single data bit is written into it. Two active-low controls, a write enable and a master clear, combine into four modes. The first mode writes only the selected cell. The second holds every cell. The third acts as a 3-to-8 decoder or demultiplexer: the selected output copies the data and all others go low. The fourth clears every cell.

The block is a clock-synchronous model of level-sensitive storage. Inputs are sampled on each rising clock edge, and the registered outputs take their new value one cycle later. A synchronous active-high reset clears all cells.

The select should only be changed while the block is in hold mode. Because hold ignores the select and the data, a multi-bit select change made there can never land on a wrong cell.

Top module: `addr_latch_bank`

## Requirements
- R1: One cycle after a rising clock edge on which `rst` is high, all eight outputs are 0, whatever the other inputs are.
- R2: With `clr_n`=1 and `we_n`=0 (write mode), the cell whose index equals the binary value of `sel` (`sel`=0 is `q[0]`, `sel`=7 is `q[7]`) takes `din` after the edge. Every other cell keeps its value.
- R3: With `clr_n`=1 and `we_n`=1 (hold mode), all outputs keep their values after the edge, for any `sel` and `din`.
- R4: With `clr_n`=0 and `we_n`=0 (decode mode), after the edge the output `q[sel]` equals `din` and every other output is 0.
- R5: With `clr_n`=0 and `we_n`=1 (clear mode), all outputs are 0 after the edge, for any `sel` and `din`.
- R6: Moving from decode mode into hold mode keeps the decoded pattern. The selected bit keeps the last `din`, and all other bits stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all cells |
| din | input | 1 | Data bit to be written or routed |
| sel | input | 3 | Binary index of the target cell |
| we_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low master clear |
| q | output | 8 | Registered outputs of the eight cells |

## Verification
A corrupted cell shows directly on its own output bit one cycle after the edge that caused it, because every cell drives a port with no logic in between. A fault stays visible through later hold cycles until a write, decode, clear or reset replaces it. The bench therefore compares all eight bits after every edge against a bench model, so a stray write to a non-selected cell is caught on the very cycle it happens. Long hold runs with a changing select and data confirm that nothing leaks in while the block is idle.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE  = 2'd0,
    MODE_HOLD   = 2'd1,
    MODE_DECODE = 2'd2,
    MODE_CLEAR  = 2'd3
  } mode_e;
endpackage

// File: rtl/latch_mode_dec.sv
module latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  we_n,
  input  logic  clr_n,
  output mode_e mode
);
  // The two active-low controls select one of four modes.
  always_comb begin
    case ({clr_n, we_n})
      2'b10:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DECODE;
      default: mode = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/latch_sel_dec.sv
module latch_sel_dec #(
  parameter int NBITS = 8,
  parameter int AW    = 3
) (
  input  logic [AW-1:0]    sel,
  output logic [NBITS-1:0] hot
);
  // One-hot decode of the binary select; bit g is set when sel == g.
  for (genvar g = 0; g < NBITS; g++) begin : g_hot
    localparam logic [AW-1:0] IDX = AW'(g);
    assign hot[g] = (sel == IDX);
  end
endmodule

// File: rtl/latch_cell_bank.sv
module latch_cell_bank
  import addr_latch_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic [NBITS-1:0] hot,
  input  logic             din,
  output logic [NBITS-1:0] q
);
  // One register per storage cell; each cell only looks at its own select line.
  for (genvar g = 0; g < NBITS; g++) begin : g_cell
    logic cell_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        cell_r <= 1'b0;
      end else begin
        case (mode)
          MODE_WRITE:  if (hot[g]) cell_r <= din;
          MODE_DECODE: cell_r <= hot[g] & din;
          MODE_CLEAR:  cell_r <= 1'b0;
          default:     cell_r <= cell_r;
        endcase
      end
    end
    assign q[g] = cell_r;
  end

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_WRITE_ONLY_SEL: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE) |=> ((($past(q) ^ q) & ~$past(hot)) == '0)); // R2
  AST_WRITE_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE) |=> ((q & $past(hot)) == ($past(din) ? $past(hot) : '0))); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |=> $stable(q)); // R3
  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DECODE) |=> (q == ($past(din) ? $past(hot) : '0))); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CLEAR) |=> (q == '0)); // R5
  AST_DECODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && $past(mode) == MODE_DECODE) |=> ($countones(q) <= 1)); // R6
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int NBITS = 8,
  localparam int AW   = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [AW-1:0]    sel,
  input  logic             we_n,
  input  logic             clr_n,
  output logic [NBITS-1:0] q
);
  mode_e            mode;
  logic [NBITS-1:0] hot;

  latch_mode_dec u_mode (
    .we_n  (we_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  latch_sel_dec #(.NBITS(NBITS), .AW(AW)) u_sel (
    .sel (sel),
    .hot (hot)
  );

  latch_cell_bank #(.NBITS(NBITS)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .hot  (hot),
    .din  (din),
    .q    (q)
  );
endmodule

// File: tb/sim_addr_latch_bank.sv
module sim_addr_latch_bank;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         din = 1'b0;
  logic [2:0]   sel = 3'd0;
  logic         we_n = 1'b1;
  logic         clr_n = 1'b1;
  logic [N-1:0] q;
  logic [N-1:0] model = '0;
  int           total = 0;
  int           bad = 0;

  always #2 clk = ~clk;

  addr_latch_bank #(.NBITS(N)) u0 (
    .clk(clk), .rst(rst), .din(din), .sel(sel),
    .we_n(we_n), .clr_n(clr_n), .q(q)
  );

  function automatic logic [N-1:0] next_q(input logic [N-1:0] cur, input logic c,
                                          input logic w, input logic [2:0] s,
                                          input logic d);
    logic [N-1:0] r;
    r = cur;
    if (c && !w)       r[s] = d;                   // R2
    else if (!c && !w) r = d ? (N'(1) << s) : '0;   // R4
    else if (!c && w)  r = '0;                      // R5
    return r;                                       // R3 hold
  endfunction

  function automatic string mode_tag(input logic r, input logic c, input logic w);
    if (r) return "R1";
    if (c && !w) return "R2";
    if (c && w) return "R3";
    if (!w) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, q, exp);
    end
  endtask

  task automatic step(input logic r, input logic c, input logic w,
                      input logic [2:0] s, input logic d, input string tag);
    @(negedge clk);
    rst = r; clr_n = c; we_n = w; sel = s; din = d;
    @(posedge clk);
    model = r ? '0 : next_q(model, c, w, s, d);
    #1;
    check(tag, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    // R1: reset state, with other inputs set to write a 1
    step(1'b1, 1'b1, 1'b0, 3'd5, 1'b1, "R1");
    step(1'b1, 1'b0, 1'b0, 3'd2, 1'b1, "R1");
    // R2: write a 1 to each cell in turn, then clear odd ones
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, 3'(i), 1'b1, "R2");
    for (int i = 1; i < N; i += 2) step(1'b0, 1'b1, 1'b0, 3'(i), 1'b0, "R2");
    // R3: hold with a moving select and data
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b1, 3'(i), i[0], "R3");
    // R4: decode each index with data 1, and once with data 0
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b0, 3'(N - 1 - i), 1'b1, "R4");
    step(1'b0, 1'b0, 1'b0, 3'd3, 1'b0, "R4");
    // R6: decode, then hold with a changing select keeps the pattern
    step(1'b0, 1'b0, 1'b0, 3'd6, 1'b1, "R6");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 3'(i), ~i[0], "R6");
    // R5: fill the cells, then clear-all
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, 1'b0, 3'(i), 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, 3'd4, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b1, 3'd1, 1'b1, "R5");
    // mixed random traffic, with an occasional reset
    for (int i = 0; i < 3000; i++) begin
      logic r, c, w, d;
      logic [2:0] s;
      r = ($urandom % 40) == 0;
      c = ($urandom % 5) != 0;
      w = $urandom % 2;
      s = 3'($urandom % 8);
      d = $urandom % 2;
      step(r, c, w, s, d, mode_tag(r, c, w));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule